// File: doc/BRIEF.md
# MMU Access Check and Exception Encoder

This block sits next to an address translation unit. It takes one memory access per cycle, together with the outcome of a TLB lookup that is done elsewhere, and decides whether the access may proceed. The checks cover alignment, the user-mode address ranges, the store-queue window and the page permission and dirty bits of the matched entry. A permitted access leaves with its physical address. A refused access leaves with a fault class, an exception event code and a vector offset, and the faulting address is kept for the exception handler.

Every access also produces the remote address of a store-queue burst. When translation is off, this address is built from one of two base values. When translation is on, it comes from the translated address. All results are registered and appear one cycle after the request.

Top module: `mmu_access_check`

## Requirements
- R1: An access whose address is not a multiple of its size (req_size: 0=1, 1=2, 2=4, 3=8 bytes) gives fault class ADDR (rsp_fault=1). This check comes before all others.
- R2: A data write (req_kind=1) whose address bits [31:26] are 6'b111000 is a store-queue write. It gives ADDR if address bits [1:0] are nonzero, or if sq_user_block=1 and user_mode=1. Otherwise, with xlat_en=1 it goes through the TLB checks of R5 and R6. A store-queue write that passes leaves with rsp_paddr equal to the virtual address.
- R3: In user mode, any other access with address bit 31 set gives ADDR.
- R4: An access passes untranslated (rsp_paddr = virtual address) in three cases: privileged mode with bits [31:26] equal to 6'b011111; privileged mode with bits [31:29] equal to 3'b100, 3'b101 or 3'b111; or xlat_en=0. In every other case, a passing access takes rsp_paddr from tlb_paddr.
- R5: On a translated access, tlb_status 0 (miss) gives fault class MISS (2) and tlb_status 2 (multi-hit) gives MULTI (3). tlb_status 1 is a single hit.
- R6: On a hit, tlb_prot[1]=0 in user mode gives PROT (4). For a data write, tlb_prot[0]=0 then gives PROT, and after that tlb_dirty=0 gives FIRSTWR (5). Read and fetch ignore tlb_prot[0] and tlb_dirty.
- R7: MISS encodes event 0x060 for a data write and 0x040 for a read or fetch (req_kind 0 or 2), each with vector 0x400.
- R8: PROT encodes 0x0C0 for a write and 0x0A0 for a read or fetch. FIRSTWR encodes 0x080. ADDR encodes 0x100 for a write and 0x0E0 for a read or fetch. All of these use vector 0x100. A pass (0) or MULTI gives event 0 and vector 0. A faulting access gives rsp_paddr 0.
- R9: Any nonzero fault class loads tea with the virtual address and pteh_vpn with the address shifted right by 10. A pass leaves both unchanged.
- R10: rsp_sq_addr is sq_base1 (if address bit 5 is 1) or sq_base0, plus the address with bits [4:0] cleared, when xlat_en=0. When xlat_en=1 it is tlb_paddr with bits [4:0] cleared.
- R11: rsp_valid is req_valid delayed by one cycle, and the results belong to that request. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 data read, 1 data write, 2 instruction fetch |
| req_size | input | 2 | log2 of access size in bytes |
| user_mode | input | 1 | 1 when the CPU runs in user mode |
| sq_user_block | input | 1 | Forbid user-mode store-queue writes |
| xlat_en | input | 1 | Address translation enabled |
| tlb_status | input | 2 | 0 miss, 1 hit, 2 multi-hit |
| tlb_prot | input | 2 | Matched entry: bit1 privileged-only when 0, bit0 writable |
| tlb_dirty | input | 1 | Matched entry dirty bit |
| tlb_paddr | input | 32 | Translated address from the lookup |
| sq_base0 | input | 32 | Store-queue base for address bit 5 = 0 |
| sq_base1 | input | 32 | Store-queue base for address bit 5 = 1 |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 3 | Fault class |
| rsp_event | output | 12 | Exception event code |
| rsp_vector | output | 12 | Exception vector offset |
| rsp_paddr | output | 32 | Physical address of a passing access |
| rsp_sq_addr | output | 32 | Store-queue remote address |
| tea | output | 32 | Last faulting address |
| pteh_vpn | output | 22 | Page number of last faulting address |

## Verification
The assertions assume that req_kind never takes the value 3 and that tlb_status never takes the value 3. They also assume that the TLB inputs are settled in the cycle of the request. The stimulus draws access kinds and lookup outcomes only from the defined encodings. Addresses are drawn from the store-queue window, the privileged pass-through windows, the translated range and the low user range, so that each priority branch is reached, together with sizes that are both aligned and misaligned.

// File: rtl/mmuchk_pkg.sv
package mmuchk_pkg;
    localparam int EV_W = 12;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2
    } kind_t;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_ADDR    = 3'd1,
        FLT_MISS    = 3'd2,
        FLT_MULTI   = 3'd3,
        FLT_PROT    = 3'd4,
        FLT_FIRSTWR = 3'd5
    } fault_t;

    localparam logic [1:0] LK_MISS  = 2'd0;
    localparam logic [1:0] LK_HIT   = 2'd1;
    localparam logic [1:0] LK_MULTI = 2'd2;
endpackage

// File: rtl/mmuchk_classify.sv
module mmuchk_classify
    import mmuchk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        kind,
    input  logic [1:0]        size,
    input  logic              user_mode,
    input  logic              sq_user_block,
    input  logic              xlat_en,
    input  logic [1:0]        tlb_status,
    input  logic [1:0]        tlb_prot,
    input  logic              tlb_dirty,
    input  logic [ADDR_W-1:0] tlb_paddr,
    output fault_t            fault,
    output logic [ADDR_W-1:0] paddr
);
    localparam int TOP6 = ADDR_W - 6;

    logic [2:0]        low_mask;
    logic              misaligned;
    logic [5:0]        hi6;
    logic [2:0]        hi3;
    logic              is_write;
    logic              use_tlb;
    logic [ADDR_W-1:0] pass_addr;

    always_comb begin
        low_mask   = 3'b111 >> (2'd3 - size);
        misaligned = |(vaddr[2:0] & low_mask);
        hi6        = vaddr[ADDR_W-1:TOP6];
        hi3        = vaddr[ADDR_W-1:ADDR_W-3];
        is_write   = (kind == KIND_WRITE);
        fault      = FLT_NONE;
        use_tlb    = 1'b0;
        pass_addr  = vaddr;

        if (misaligned) begin
            fault = FLT_ADDR;
        end else if (is_write && hi6 == 6'b111000) begin
            if (vaddr[1:0] != 2'b00 || (sq_user_block && user_mode))
                fault = FLT_ADDR;
            else
                use_tlb = xlat_en;
        end else if (user_mode && vaddr[ADDR_W-1]) begin
            fault = FLT_ADDR;
        end else if (!user_mode && hi6 == 6'b011111) begin
            pass_addr = vaddr;
        end else if (!xlat_en || (!user_mode &&
                     (hi3 == 3'b100 || hi3 == 3'b101 || hi3 == 3'b111))) begin
            pass_addr = vaddr;
        end else begin
            use_tlb   = 1'b1;
            pass_addr = tlb_paddr;
        end

        if (use_tlb) begin
            if (tlb_status == LK_MULTI)
                fault = FLT_MULTI;
            else if (tlb_status != LK_HIT)
                fault = FLT_MISS;
            else if (!tlb_prot[1] && user_mode)
                fault = FLT_PROT;
            else if (is_write && !tlb_prot[0])
                fault = FLT_PROT;
            else if (is_write && !tlb_dirty)
                fault = FLT_FIRSTWR;
        end

        paddr = (fault == FLT_NONE) ? pass_addr : '0;
    end
endmodule

// File: rtl/mmuchk_encode.sv
module mmuchk_encode
    import mmuchk_pkg::*;
(
    input  fault_t          fault,
    input  logic [1:0]      kind,
    output logic [EV_W-1:0] event_code,
    output logic [EV_W-1:0] vector
);
    logic wr;

    always_comb begin
        wr         = (kind == KIND_WRITE);
        event_code = '0;
        vector     = EV_W'(12'h100);
        unique case (fault)
            FLT_MISS: begin
                event_code = wr ? EV_W'(12'h060) : EV_W'(12'h040);
                vector     = EV_W'(12'h400);
            end
            FLT_PROT:    event_code = wr ? EV_W'(12'h0C0) : EV_W'(12'h0A0);
            FLT_FIRSTWR: event_code = EV_W'(12'h080);
            FLT_ADDR:    event_code = wr ? EV_W'(12'h100) : EV_W'(12'h0E0);
            default:     vector     = '0;
        endcase
    end
endmodule

// File: rtl/mmuchk_sqaddr.sv
module mmuchk_sqaddr #(
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 5
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              xlat_en,
    input  logic [ADDR_W-1:0] tlb_paddr,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    output logic [ADDR_W-1:0] sq_addr
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_SHIFT) - ADDR_W'(1));

    always_comb begin
        if (xlat_en)
            sq_addr = tlb_paddr & LINE_MASK;
        else
            sq_addr = (vaddr[LINE_SHIFT] ? base1 : base0) + (vaddr & LINE_MASK);
    end
endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
    import mmuchk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic [1:0]                 req_kind,
    input  logic [1:0]                 req_size,
    input  logic                       user_mode,
    input  logic                       sq_user_block,
    input  logic                       xlat_en,
    input  logic [1:0]                 tlb_status,
    input  logic [1:0]                 tlb_prot,
    input  logic                       tlb_dirty,
    input  logic [ADDR_W-1:0]          tlb_paddr,
    input  logic [ADDR_W-1:0]          sq_base0,
    input  logic [ADDR_W-1:0]          sq_base1,
    output logic                       rsp_valid,
    output logic [2:0]                 rsp_fault,
    output logic [EV_W-1:0]            rsp_event,
    output logic [EV_W-1:0]            rsp_vector,
    output logic [ADDR_W-1:0]          rsp_paddr,
    output logic [ADDR_W-1:0]          rsp_sq_addr,
    output logic [ADDR_W-1:0]          tea,
    output logic [ADDR_W-PAGE_SHIFT-1:0] pteh_vpn
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    typedef struct packed {
        logic              valid;
        fault_t            fault;
        logic [EV_W-1:0]   ev;
        logic [EV_W-1:0]   vec;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] sq;
        logic [ADDR_W-1:0] tea;
        logic [VPN_W-1:0]  vpn;
    } state_t;

    state_t            st_d, st_q;
    fault_t            fault_c;
    logic [ADDR_W-1:0] paddr_c;
    logic [ADDR_W-1:0] sq_c;
    logic [EV_W-1:0]   ev_c;
    logic [EV_W-1:0]   vec_c;

    mmuchk_classify #(.ADDR_W(ADDR_W)) u_classify (
        .vaddr(req_vaddr), .kind(req_kind), .size(req_size),
        .user_mode(user_mode), .sq_user_block(sq_user_block), .xlat_en(xlat_en),
        .tlb_status(tlb_status), .tlb_prot(tlb_prot), .tlb_dirty(tlb_dirty),
        .tlb_paddr(tlb_paddr), .fault(fault_c), .paddr(paddr_c)
    );

    mmuchk_encode u_encode (
        .fault(fault_c), .kind(req_kind), .event_code(ev_c), .vector(vec_c)
    );

    mmuchk_sqaddr #(.ADDR_W(ADDR_W)) u_sqaddr (
        .vaddr(req_vaddr), .xlat_en(xlat_en), .tlb_paddr(tlb_paddr),
        .base0(sq_base0), .base1(sq_base1), .sq_addr(sq_c)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.fault = fault_c;
            st_d.ev    = ev_c;
            st_d.vec   = vec_c;
            st_d.paddr = paddr_c;
            st_d.sq    = sq_c;
            if (fault_c != FLT_NONE) begin
                st_d.tea = req_vaddr;
                st_d.vpn = req_vaddr[ADDR_W-1:PAGE_SHIFT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.valid;
    assign rsp_fault   = st_q.fault;
    assign rsp_event   = st_q.ev;
    assign rsp_vector  = st_q.vec;
    assign rsp_paddr   = st_q.paddr;
    assign rsp_sq_addr = st_q.sq;
    assign tea         = st_q.tea;
    assign pteh_vpn    = st_q.vpn;

    assert_misalign_addr_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((32'(req_vaddr) % (32'd1 << req_size)) != 0))
        |=> (rsp_fault == 3'd1));

    assert_follow_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid == 1'b0 |=> !rsp_valid);

    assert_miss_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd2) |-> (rsp_vector == EV_W'(12'h400)));

    assert_pass_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd0) |-> (rsp_event == '0 && rsp_vector == '0));

    assert_fault_tea_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault == 3'd0) || (tea == $past(req_vaddr)));

    assert_pass_tea_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault != 3'd0) || ($stable(tea) && $stable(pteh_vpn)));
endmodule

// File: tb/mmu_access_check_bench.sv
`timescale 1ns/1ps
module mmu_access_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0, req_size = '0;
    logic        user_mode = 1'b0, sq_user_block = 1'b0, xlat_en = 1'b0;
    logic [1:0]  tlb_status = '0, tlb_prot = '0;
    logic        tlb_dirty = 1'b0;
    logic [31:0] tlb_paddr = '0;
    logic [31:0] sq_base0 = 32'h1000_0000, sq_base1 = 32'h2340_0000;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [11:0] rsp_event, rsp_vector;
    logic [31:0] rsp_paddr, rsp_sq_addr, tea;
    logic [21:0] pteh_vpn;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_tea = '0;

    always #2 clk = ~clk;

    mmu_access_check u_mmu_access_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_size(req_size), .user_mode(user_mode),
        .sq_user_block(sq_user_block), .xlat_en(xlat_en), .tlb_status(tlb_status),
        .tlb_prot(tlb_prot), .tlb_dirty(tlb_dirty), .tlb_paddr(tlb_paddr),
        .sq_base0(sq_base0), .sq_base1(sq_base1), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_event(rsp_event), .rsp_vector(rsp_vector),
        .rsp_paddr(rsp_paddr), .rsp_sq_addr(rsp_sq_addr), .tea(tea), .pteh_vpn(pteh_vpn)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model built from the requirement list
    function automatic void ref_model(input logic [31:0] va, input logic [1:0] k, sz,
            input logic u, sqb, xl, input logic [1:0] ts, pr, input logic d,
            input logic [31:0] tp, output logic [2:0] f, output logic [31:0] pa);
        logic tlbpath;
        tlbpath = 1'b0;
        f = 3'd0;
        pa = va;
        if ((va % (32'd1 << sz)) != 0) f = 3'd1;                       // R1
        else if (k == 2'd1 && va[31:26] == 6'b111000) begin            // R2
            if (va[1:0] != 0 || (sqb && u)) f = 3'd1;
            else tlbpath = xl;
        end else if (u && va[31]) f = 3'd1;                            // R3
        else if (!u && va[31:26] == 6'b011111) pa = va;                // R4
        else if (!xl || (!u && va[31:29] inside {3'd4, 3'd5, 3'd7})) pa = va;
        else begin tlbpath = 1'b1; pa = tp; end
        if (tlbpath) begin
            if (ts == 2'd2) f = 3'd3;                                  // R5
            else if (ts != 2'd1) f = 3'd2;
            else if (!pr[1] && u) f = 3'd4;                            // R6
            else if (k == 2'd1 && !pr[0]) f = 3'd4;
            else if (k == 2'd1 && !d) f = 3'd5;
        end
        if (f != 0) pa = '0;
    endfunction

    function automatic logic [23:0] ref_code(input logic [2:0] f, input logic [1:0] k);
        logic w;
        w = (k == 2'd1);
        case (f)
            3'd2: return {w ? 12'h060 : 12'h040, 12'h400};             // R7
            3'd4: return {w ? 12'h0C0 : 12'h0A0, 12'h100};             // R8
            3'd5: return {12'h080, 12'h100};
            3'd1: return {w ? 12'h100 : 12'h0E0, 12'h100};
            default: return 24'h0;
        endcase
    endfunction

    task automatic access(input logic [31:0] va, input logic [1:0] k, sz,
            input logic u, sqb, xl, input logic [1:0] ts, pr, input logic d,
            input logic [31:0] tp, input string tag);
        logic [2:0]  ef;
        logic [31:0] epa, esq;
        logic [23:0] ec;
        req_vaddr = va; req_kind = k; req_size = sz; user_mode = u;
        sq_user_block = sqb; xlat_en = xl; tlb_status = ts; tlb_prot = pr;
        tlb_dirty = d; tlb_paddr = tp; req_valid = 1'b1;
        ref_model(va, k, sz, u, sqb, xl, ts, pr, d, tp, ef, epa);
        ec  = ref_code(ef, k);
        esq = xl ? (tp & ~32'h1F) : ((va[5] ? sq_base1 : sq_base0) + (va & ~32'h1F));
        if (ef != 0) exp_tea = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R11", "valid", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == ef, tag, "fault", 64'(rsp_fault), 64'(ef));
        chk({rsp_event, rsp_vector} == ec, "R7 R8", "code", 64'({rsp_event, rsp_vector}), 64'(ec));
        chk(rsp_paddr == epa, "R4", "paddr", 64'(rsp_paddr), 64'(epa));
        chk(rsp_sq_addr == esq, "R10", "sq_addr", 64'(rsp_sq_addr), 64'(esq));
        chk(tea == exp_tea && pteh_vpn == exp_tea[31:10], "R9", "tea/vpn",
            64'({tea, pteh_vpn}), 64'({exp_tea, exp_tea[31:10]}));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(rsp_valid == 0 && tea == 0 && rsp_fault == 0 && rsp_paddr == 0, "R11", "reset",
            64'({rsp_valid, rsp_fault, tea}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(32'h0000_1001, 2'd0, 2'd1, 0, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R1");
        access(32'h0000_2006, 2'd1, 2'd2, 0, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R1");
        access(32'h0000_3004, 2'd2, 2'd3, 0, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R1");
        access(32'hE000_0042, 2'd1, 2'd1, 0, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R2");
        access(32'hE100_0040, 2'd1, 2'd2, 1, 1, 1, 2'd1, 2'd3, 1, 32'h0, "R2");
        access(32'hE200_0060, 2'd1, 2'd2, 1, 0, 1, 2'd1, 2'd3, 1, 32'h0C00_0060, "R2");
        access(32'hE300_0080, 2'd1, 2'd2, 0, 0, 1, 2'd1, 2'd3, 0, 32'h0C00_0080, "R2");
        access(32'hE000_0020, 2'd1, 2'd2, 1, 1, 0, 2'd0, 2'd0, 0, 32'h0, "R2");
        access(32'hE000_0004, 2'd1, 2'd2, 0, 1, 0, 2'd0, 2'd0, 0, 32'h0, "R10");
        access(32'hE000_0024, 2'd1, 2'd2, 0, 1, 0, 2'd0, 2'd0, 0, 32'h0, "R10");
        access(32'hA000_0000, 2'd0, 2'd2, 1, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R3");
        access(32'hE000_0000, 2'd0, 2'd2, 1, 0, 1, 2'd1, 2'd3, 1, 32'h0, "R3");
        access(32'h7C00_1234, 2'd0, 2'd0, 0, 0, 1, 2'd0, 2'd0, 0, 32'h5555_0000, "R4");
        access(32'h7C00_1234, 2'd0, 2'd0, 1, 0, 1, 2'd0, 2'd0, 0, 32'h5555_0000, "R4");
        access(32'h8C00_0010, 2'd1, 2'd2, 0, 0, 1, 2'd0, 2'd0, 0, 32'h0, "R4");
        access(32'hC000_0010, 2'd1, 2'd2, 0, 0, 1, 2'd0, 2'd0, 0, 32'h0, "R5");
        access(32'h0040_0010, 2'd0, 2'd2, 1, 0, 0, 2'd0, 2'd0, 0, 32'h0, "R4");
        access(32'h0040_0010, 2'd1, 2'd2, 1, 0, 1, 2'd0, 2'd3, 1, 32'h0, "R5");
        access(32'h0040_0020, 2'd2, 2'd1, 1, 0, 1, 2'd0, 2'd3, 1, 32'h0, "R5");
        access(32'h0050_0000, 2'd0, 2'd2, 1, 0, 1, 2'd2, 2'd3, 1, 32'h0, "R5");
        access(32'h0060_0000, 2'd2, 2'd1, 1, 0, 1, 2'd1, 2'd1, 1, 32'h0, "R6");
        access(32'h0060_0004, 2'd1, 2'd2, 0, 0, 1, 2'd1, 2'd2, 1, 32'h0, "R6");
        access(32'h0060_0008, 2'd0, 2'd2, 1, 0, 1, 2'd1, 2'd2, 0, 32'h0770_0008, "R6");
        access(32'h0060_000C, 2'd1, 2'd2, 0, 0, 1, 2'd1, 2'd3, 0, 32'h0, "R6");
        access(32'h0060_0010, 2'd1, 2'd2, 1, 0, 1, 2'd1, 2'd3, 1, 32'h0990_0010, "R6");
        // R11 idle cycle gives no response
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", "idle", 64'(rsp_valid), 64'd0);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r, va;
            r = $urandom;
            case ($urandom % 6)
                0: va = {6'b111000, r[25:0]};
                1: va = {6'b011111, r[25:0]};
                2: va = {3'b100, r[28:0]};
                3: va = {3'b110, r[28:0]};
                4: va = {3'b111, r[28:0]};
                default: va = {1'b0, r[30:0]};
            endcase
            if ($urandom % 3 != 0) va[2:0] = 3'b000;
            access(va, 2'($urandom % 3), 2'($urandom), 1'($urandom), 1'($urandom),
                   1'($urandom % 4 != 0), 2'($urandom % 3), 2'($urandom), 1'($urandom),
                   $urandom, "R1 R2 R3 R5 R6");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule